// File: doc/BRIEF.md
# Keyed Associative Store

The block is a small associative memory with a fixed number of slots. Each slot holds a key, a data payload and a valid bit. Four independent request ports act on it by key: an insert port places a new key/data pair into a free slot, a lookup port returns the data held under a key, an update port replaces the data held under a key, and a delete port invalidates the slot holding a key. Every keyed request compares its key against all occupied slots at once. Lookup and update each report a miss flag when no occupied slot carries the key.

Each port has a valid/ready pair. Lookup, update and delete are always ready, and their responses are combinational in the cycle of the request. The insert port is ready only while at least one slot is free, and it fills the lowest-numbered free slot. All four ports may fire in the same cycle. Every comparison and the free-slot choice use the contents held before the clock edge. The changes then commit at that edge in a fixed order: delete, then update, then insert. The caller must never insert a key that is already stored.

Top module: `kv_assoc_store`

## Requirements
- R1: After synchronous reset no slot is occupied: every lookup misses and the insert port is ready.
- R2: A lookup of a stored key returns that key's data on the lookup data output with the miss flag low.
- R3: A lookup of a key held by no occupied slot raises the miss flag and drives the lookup data output to zero.
- R4: An update of a stored key lowers its miss flag, and from the next cycle lookups of that key return the new data.
- R5: An update of a key that is not stored raises its miss flag and leaves every stored pair unchanged.
- R6: A delete makes its key absent from the next cycle. Deleting an absent key changes no stored pair.
- R7: An accepted insert makes its pair readable from the next cycle. The insert port's ready is low exactly when every slot is occupied, and an insert offered while ready is low is dropped.
- R8: Requests in the same cycle see the contents from before the edge: a lookup of a key deleted in that cycle still hits with the old data, and a lookup of a key inserted in that cycle misses.
- R9: Same-cycle changes commit as delete, then update, then insert. An update and a delete of the same key leave the key absent. A delete in a cycle where all slots are occupied does not make the insert port ready in that cycle.
- R10: The lookup, update and delete ports are always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free slot exists |
| ins_key | input | KEY_W | Key to insert |
| ins_data | input | DATA_W | Data to insert |
| lkp_valid | input | 1 | Lookup request |
| lkp_ready | output | 1 | Lookup port ready (always high) |
| lkp_key | input | KEY_W | Key to look up |
| lkp_data | output | DATA_W | Data of the matching slot, zero on a miss |
| lkp_miss | output | 1 | No occupied slot holds the lookup key |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Update port ready (always high) |
| upd_key | input | KEY_W | Key whose data is replaced |
| upd_data | input | DATA_W | Replacement data |
| upd_miss | output | 1 | No occupied slot holds the update key |
| del_valid | input | 1 | Delete request |
| del_ready | output | 1 | Delete port ready (always high) |
| del_key | input | KEY_W | Key to delete |

## Verification
The embedded assertions assume that no key is ever inserted while it is already stored, so at most one occupied slot can match any key. The one-hot checks on the match vectors and the slot-count checks rely on that. The stimulus enforces it by drawing every insert key from the keys its own model does not hold. It still issues updates, deletes and lookups of keys both present and absent, and it offers inserts while the store is full. Directed cycles combine deletes, updates, inserts and lookups of the same key to exercise the commit order.

// File: rtl/kvs_pkg.sv
package kvs_pkg;
    localparam int unsigned KVS_DEF_SLOTS  = 8;
    localparam int unsigned KVS_DEF_KEY_W  = 4;
    localparam int unsigned KVS_DEF_DATA_W = 5;
endpackage

// File: rtl/kvs_key_match.sv
module kvs_key_match #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned KEY_W = 4
) (
    input  logic [SLOTS-1:0][KEY_W-1:0] slot_key,
    input  logic [SLOTS-1:0]            slot_used,
    input  logic [KEY_W-1:0]            probe_key,
    output logic [SLOTS-1:0]            hit_vec
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = slot_used[g] && (slot_key[g] == probe_key);
    end
endmodule

// File: rtl/kvs_free_pick.sv
module kvs_free_pick #(
    parameter int unsigned SLOTS = 8
) (
    input  logic [SLOTS-1:0] slot_used,
    output logic [SLOTS-1:0] pick_oh,
    output logic             any_free
);
    logic [SLOTS-1:0] taken;

    always_comb begin
        pick_oh = '0;
        taken   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!slot_used[i] && (taken == '0)) begin
                pick_oh[i] = 1'b1;
            end
            if (!slot_used[i]) begin
                taken[i] = 1'b1;
            end
        end
        any_free = |taken;
    end
endmodule

// File: rtl/kvs_onehot_mux.sv
module kvs_onehot_mux #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned DATA_W = 5
) (
    input  logic [SLOTS-1:0]             sel_oh,
    input  logic [SLOTS-1:0][DATA_W-1:0] slot_data,
    output logic [DATA_W-1:0]            sel_data
);
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (sel_oh[i]) begin
                sel_data = sel_data | slot_data[i];
            end
        end
    end
endmodule

// File: rtl/kv_assoc_store.sv
module kv_assoc_store
    import kvs_pkg::*;
#(
    parameter int unsigned SLOTS  = KVS_DEF_SLOTS,
    parameter int unsigned KEY_W  = KVS_DEF_KEY_W,
    parameter int unsigned DATA_W = KVS_DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              lkp_valid,
    output logic              lkp_ready,
    input  logic [KEY_W-1:0]  lkp_key,
    output logic [DATA_W-1:0] lkp_data,
    output logic              lkp_miss,
    input  logic              upd_valid,
    output logic              upd_ready,
    input  logic [KEY_W-1:0]  upd_key,
    input  logic [DATA_W-1:0] upd_data,
    output logic              upd_miss,
    input  logic              del_valid,
    output logic              del_ready,
    input  logic [KEY_W-1:0]  del_key
);
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SLOTS-1:0]             used;
        logic [SLOTS-1:0][KEY_W-1:0]  key;
        logic [SLOTS-1:0][DATA_W-1:0] data;
    } store_t;

    store_t st_q, st_d;

    logic [SLOTS-1:0] lkp_hit, upd_hit, del_hit, free_oh;
    logic             any_free;
    logic             ins_fire, upd_fire, del_fire;
    logic [DATA_W-1:0] lkp_sel;

    kvs_key_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_match_lkp (
        .slot_key(st_q.key), .slot_used(st_q.used), .probe_key(lkp_key), .hit_vec(lkp_hit));
    kvs_key_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_match_upd (
        .slot_key(st_q.key), .slot_used(st_q.used), .probe_key(upd_key), .hit_vec(upd_hit));
    kvs_key_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_match_del (
        .slot_key(st_q.key), .slot_used(st_q.used), .probe_key(del_key), .hit_vec(del_hit));

    kvs_free_pick #(.SLOTS(SLOTS)) u_free (
        .slot_used(st_q.used), .pick_oh(free_oh), .any_free(any_free));

    kvs_onehot_mux #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_rd_mux (
        .sel_oh(lkp_hit), .slot_data(st_q.data), .sel_data(lkp_sel));

    assign ins_ready = any_free;
    assign lkp_ready = 1'b1;
    assign upd_ready = 1'b1;
    assign del_ready = 1'b1;

    assign ins_fire = ins_valid && ins_ready;
    assign upd_fire = upd_valid && upd_ready;
    assign del_fire = del_valid && del_ready;

    assign lkp_data = lkp_sel;
    assign lkp_miss = ~|lkp_hit;
    assign upd_miss = ~|upd_hit;

    // Next-state: delete, then update, then insert, all decided on st_q.
    always_comb begin
        st_d = st_q;
        if (del_fire) begin
            st_d.used = st_d.used & ~del_hit;
        end
        if (upd_fire) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (upd_hit[i]) begin
                    st_d.data[i] = upd_data;
                end
            end
        end
        if (ins_fire) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (free_oh[i]) begin
                    st_d.used[i] = 1'b1;
                    st_d.key[i]  = ins_key;
                    st_d.data[i] = ins_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.used <= '0;
            st_q.key  <= '0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [CNT_W-1:0] used_cnt;
    assign used_cnt = CNT_W'($countones(st_q.used));

    // R2
    lkp_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lkp_hit));

    // R7
    free_pick_chk: assert property (@(posedge clk) disable iff (rst)
        ins_fire |-> ($onehot(free_oh) && ((free_oh & st_q.used) == '0)));

    // R7
    ins_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && !(del_fire && |del_hit)) |=> used_cnt == $past(used_cnt) + 1'b1);

    // R6
    del_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (del_fire && |del_hit && !ins_fire) |=> used_cnt == $past(used_cnt) - 1'b1);

    // R5
    upd_miss_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && upd_miss && !ins_fire && !(del_fire && |del_hit)) |=> $stable(st_q));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && lkp_miss) |-> lkp_data == '0);
endmodule

// File: tb/kv_assoc_store_bench.sv
module kv_assoc_store_bench;
    localparam int SLOTS = 8;
    localparam int KW = 4;
    localparam int DW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 0, lkp_valid = 0, upd_valid = 0, del_valid = 0;
    logic [KW-1:0] ins_key = 0, lkp_key = 0, upd_key = 0, del_key = 0;
    logic [DW-1:0] ins_data = 0, upd_data = 0;
    logic ins_ready, lkp_ready, upd_ready, del_ready, lkp_miss, upd_miss;
    logic [DW-1:0] lkp_data;

    int n_checks = 0;
    int n_fail = 0;
    int mdl[int];

    always #4 clk = ~clk;

    kv_assoc_store u_kv_assoc_store (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_key(ins_key), .ins_data(ins_data),
        .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_key(lkp_key),
        .lkp_data(lkp_data), .lkp_miss(lkp_miss),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_key(upd_key),
        .upd_data(upd_data), .upd_miss(upd_miss),
        .del_valid(del_valid), .del_ready(del_ready), .del_key(del_key));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare against the model before the edge, then advance the model.
    task automatic step(input bit iv, input int ik, input int id,
                        input bit lv, input int lk,
                        input bit uv, input int uk, input int ud,
                        input bit dv, input int dk, input string tag);
        bit full_pre, lhit, uhit;
        @(negedge clk);
        ins_valid = iv; ins_key = KW'(ik); ins_data = DW'(id);
        lkp_valid = lv; lkp_key = KW'(lk);
        upd_valid = uv; upd_key = KW'(uk); upd_data = DW'(ud);
        del_valid = dv; del_key = KW'(dk);
        #2;
        full_pre = (mdl.num() >= SLOTS);
        chk({"R10 ", tag}, "lkp_ready", int'(lkp_ready), 1);
        chk({"R10 ", tag}, "upd_ready", int'(upd_ready), 1);
        chk({"R10 ", tag}, "del_ready", int'(del_ready), 1);
        chk({"R7 ", tag}, "ins_ready", int'(ins_ready), int'(!full_pre));
        lhit = mdl.exists(lk);
        if (lv) begin
            chk({"R2/R3 ", tag}, "lkp_miss", int'(lkp_miss), int'(!lhit));
            chk({"R2/R3 ", tag}, "lkp_data", int'(lkp_data), lhit ? mdl[lk] : 0);
        end
        uhit = mdl.exists(uk);
        if (uv) chk({"R4/R5 ", tag}, "upd_miss", int'(upd_miss), int'(!uhit));
        if (dv && mdl.exists(dk)) mdl.delete(dk);
        if (uv && uhit && mdl.exists(uk)) mdl[uk] = ud;
        if (iv && !full_pre) mdl[ik] = id;
        @(posedge clk);
    endtask

    task automatic idle_read(input int k, input string tag);
        step(0, 0, 0, 1, k, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        for (int k = 0; k < 16; k += 5) idle_read(k, "R1 reset empty");
        // R2, R3, R7
        step(1, 3, 7, 0, 0, 0, 0, 0, 0, 0, "R7 insert");
        step(1, 9, 21, 1, 3, 0, 0, 0, 0, 0, "R7 insert");
        idle_read(3, "R2 hit");
        idle_read(9, "R2 hit");
        idle_read(5, "R3 miss");
        // R4, R5
        step(0, 0, 0, 0, 0, 1, 9, 2, 0, 0, "R4 update hit");
        idle_read(9, "R4 new data");
        step(0, 0, 0, 0, 0, 1, 12, 30, 0, 0, "R5 update miss");
        idle_read(12, "R5 still absent");
        idle_read(3, "R5 others unchanged");
        // R6
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R6 delete");
        idle_read(3, "R6 gone");
        step(0, 0, 0, 1, 9, 0, 0, 0, 1, 3, "R6 delete absent");
        // R7 fill to full, then offer an insert while full
        for (int k = 0; k < 7; k++) step(1, k + 1, k + 10, 0, 0, 0, 0, 0, 0, 0, "R7 fill");
        step(1, 15, 4, 1, 15, 0, 0, 0, 0, 0, "R7 insert while full");
        idle_read(15, "R7 dropped insert");
        // R9: delete while full does not open the insert port this cycle
        step(1, 15, 4, 0, 0, 0, 0, 0, 1, 1, "R9 delete+insert full");
        idle_read(15, "R9 insert rejected");
        // R8: lookup sees pre-edge contents
        step(0, 0, 0, 1, 2, 0, 0, 0, 1, 2, "R8 read during delete");
        step(1, 14, 17, 1, 14, 0, 0, 0, 0, 0, "R8 read during insert");
        idle_read(14, "R8 insert visible");
        // R9: update and delete of the same key
        step(0, 0, 0, 0, 0, 1, 4, 6, 1, 4, "R9 update+delete");
        idle_read(4, "R9 key absent");
        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            int ik;
            bit iv;
            ik = int'($urandom_range(0, 15));
            iv = ($urandom_range(0, 2) != 0);
            for (int t = 0; t < 16 && mdl.exists(ik); t++) ik = (ik + 1) % 16;
            if (mdl.exists(ik)) iv = 0;
            step(iv, ik, int'($urandom_range(0, 31)),
                 $urandom_range(0, 3) != 0, int'($urandom_range(0, 15)),
                 $urandom_range(0, 2) == 0, int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
                 $urandom_range(0, 3) == 0, int'($urandom_range(0, 15)), "R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule